// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Unit

This block sits between a UART's receive and transmit datapaths and the host register file. It holds the interrupt-enable byte, keeps the sticky receive error flags and the transmitter-empty state, and reduces the pending sources to one identification code and a single interrupt line. Each source is gated by its own enable bit. When several sources are active, a fixed priority selects one of them.

The host reads the identification and line status bytes through read strobes, and both reads have side effects. A line status read clears the sticky error flags. An identification read that shows the transmitter-empty code drops that request. The transmit side is tracked by a three-state machine: TX_EMPTY, TX_BUSY and TX_HELD. Its transitions are named `thr_load` (any data write, into TX_BUSY), `tx_finish` (TX_BUSY to TX_EMPTY, or to TX_HELD when programmable-empty mode is active), `mode_on` (TX_EMPTY to TX_HELD) and `mode_off` (TX_HELD to TX_EMPTY). The identification code is held in a register that is reloaded every cycle from the current flags. As a result, every change becomes visible one clock after the state that causes it, and no path leads from a read back into the code it returns.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the line status byte reads 0x60, the enable byte reads 0x00, the identification byte reads 0x01 with `fifo_en` low, and `irq` is low.
- R2: If enable bit 2 is set and any of line status bits 4:1 is set (overrun, parity, framing, break), the identification code in bits 3:0 is 0x6. This source outranks all others.
- R3: If R2 does not apply, and enable bit 0 and `rx_ready` are both set, the code is 0x4.
- R4: If R2 and R3 do not apply, and enable bit 1 is set and the transmitter-empty request is pending, the code is 0x2.
- R5: If none of the above applies, and enable bit 3 and `msr_delta` are both set, the code is 0x0.
- R6: With no enabled source active, the code is 0x1. `irq` is high exactly when the code is not 0x1. Identification bits 7:6 both equal `fifo_en`, and bits 5:4 read zero.
- R7: An identification read clears the pending transmitter-empty request only if bits 2:1 of the code show 2'b01 at the time of the read. A read that shows any other code leaves the request pending.
- R8: A line status read returns the current byte and then clears bits 7 (receive FIFO error) and 4:1. An error event that arrives in the same cycle as the read is kept. Bits 0, 5 and 6 are unaffected by the read.
- R9: A data write (`thr_wr`) clears line status bits 5 and 6 and the pending request. `tx_done` then sets bit 6, sets bit 5 (except under R10) and sets the pending request.
- R10: While `fifo_en` and enable bit 7 are both set, line status bit 5 reads zero one cycle later. In this mode `tx_done` still sets bit 6 and the pending request.
- R11: An enable write made while line status bit 5 is set, and whose new value does not select programmable-empty mode with `fifo_en` high, re-arms the pending transmitter-empty request.
- R12: The identification code and `irq` reflect the flags as they stood one clock earlier, so a source event shows in the code one cycle after it reaches the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_wr | input | 1 | Enable-byte write strobe |
| ier_wdata | input | 8 | Enable-byte write data |
| fifo_en | input | 1 | FIFO mode active |
| rx_ready | input | 1 | Received data available (level) |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_frame | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break event pulse |
| err_fifo | input | 1 | Receive FIFO error event pulse |
| msr_delta | input | 1 | Any modem status change (level) |
| thr_wr | input | 1 | Transmit data write strobe |
| tx_done | input | 1 | Transmission finished pulse |
| iir_rd | input | 1 | Identification read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| ier_rdata | output | 8 | Enable byte |
| iir_rdata | output | 8 | Identification byte |
| lsr_rdata | output | 8 | Line status byte |
| irq | output | 1 | Interrupt request |

## Verification
A table drives the priority encoder with all four sources active at once. It then removes sources one by one from the top and masks single enable bits. This separates a wrong ranking from a wrong code value and from a missing enable gate. Directed sequences then check four further behaviours. First, the one-cycle lag of the code. Second, an identification read clears the transmitter request only while the empty code is shown, and not while the receive code masks it. Third, a line status read clears the error flags, and an error that collides with the read survives it. Fourth, in programmable-empty mode the empty bit stays masked while the pending request is still raised.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int REG_W = 8;
    localparam int ERR_N = 5;

    // enable-byte bit positions
    localparam int IE_RXDATA = 0;
    localparam int IE_THRE   = 1;
    localparam int IE_LINE   = 2;
    localparam int IE_MODEM  = 3;
    localparam int IE_PROG   = 7;

    // line status bit positions
    localparam int LS_DR   = 0;
    localparam int LS_BI   = 4;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_FERR = 7;

    typedef enum logic [3:0] {
        ID_MODEM  = 4'h0,
        ID_NONE   = 4'h1,
        ID_THRE   = 4'h2,
        ID_RXDATA = 4'h4,
        ID_LINE   = 4'h6
    } irq_id_e;

    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,
        TX_BUSY  = 2'd1,
        TX_HELD  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart_err_flags.sv
module uart_err_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);

    // one sticky flop per error source; a new event beats a clearing read
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= (flags[i] & ~clr) | evt[i];
            end
        end
    end

endmodule

// File: rtl/uart_tx_tracker.sv
module uart_tx_tracker
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic tx_done,
    input  logic prog_mode,
    input  logic rearm_req,
    input  logic pend_clr,
    output logic thre,
    output logic temt,
    output logic pend
);

    tx_state_e state_q, state_d;
    logic      pend_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
            pend    <= 1'b0;
        end else begin
            state_q <= state_d;
            pend    <= pend_d;
        end
    end

    // transitions: thr_load, tx_finish, mode_on, mode_off
    always_comb begin
        state_d = state_q;
        if (thr_wr) begin
            state_d = TX_BUSY;
        end else begin
            unique case (state_q)
                TX_EMPTY: if (prog_mode) state_d = TX_HELD;
                TX_BUSY:  if (tx_done)   state_d = prog_mode ? TX_HELD : TX_EMPTY;
                TX_HELD:  if (!prog_mode) state_d = TX_EMPTY;
                default:  state_d = TX_EMPTY;
            endcase
        end
    end

    // pending request: set by finish or re-arm, cleared by load or id read
    always_comb begin
        pend_d = pend;
        if (thr_wr) begin
            pend_d = 1'b0;
        end else if ((state_q == TX_BUSY && tx_done) ||
                     (state_q == TX_EMPTY && rearm_req)) begin
            pend_d = 1'b1;
        end else if (pend_clr) begin
            pend_d = 1'b0;
        end
    end

    // outputs
    always_comb begin
        thre = (state_q == TX_EMPTY);
        temt = (state_q != TX_BUSY);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [3:0] ie,
    input  logic       line_any,
    input  logic       rx_ready,
    input  logic       thre_pend,
    input  logic       msr_delta,
    output irq_id_e    id
);

    always_comb begin
        if (ie[IE_LINE] && line_any) begin
            id = ID_LINE;
        end else if (ie[IE_RXDATA] && rx_ready) begin
            id = ID_RXDATA;
        end else if (ie[IE_THRE] && thre_pend) begin
            id = ID_THRE;
        end else if (ie[IE_MODEM] && msr_delta) begin
            id = ID_MODEM;
        end else begin
            id = ID_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [REG_W-1:0] ier_wdata,
    input  logic             fifo_en,
    input  logic             rx_ready,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_frame,
    input  logic             err_break,
    input  logic             err_fifo,
    input  logic             msr_delta,
    input  logic             thr_wr,
    input  logic             tx_done,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    output logic [REG_W-1:0] ier_rdata,
    output logic [REG_W-1:0] iir_rdata,
    output logic [REG_W-1:0] lsr_rdata,
    output logic             irq
);

    logic [REG_W-1:0] ier_q;
    logic [ERR_N-1:0] err_flags;
    logic             thre, temt, pend;
    logic             prog_mode, rearm_req, pend_clr;
    irq_id_e          id_d, id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
        end else if (ier_wr) begin
            ier_q <= ier_wdata;
        end
    end

    assign prog_mode = fifo_en & ier_q[IE_PROG];
    assign rearm_req = ier_wr & ~(fifo_en & ier_wdata[IE_PROG]);
    assign pend_clr  = iir_rd & (id_q[2:1] == 2'b01);

    // order: overrun, parity, framing, break, fifo error
    uart_err_flags #(.N(ERR_N)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   ({err_fifo, err_break, err_frame, err_parity, err_overrun}),
        .clr   (lsr_rd),
        .flags (err_flags)
    );

    uart_tx_tracker u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr),
        .tx_done   (tx_done),
        .prog_mode (prog_mode),
        .rearm_req (rearm_req),
        .pend_clr  (pend_clr),
        .thre      (thre),
        .temt      (temt),
        .pend      (pend)
    );

    uart_irq_prio u_prio (
        .ie        (ier_q[3:0]),
        .line_any  (|lsr_rdata[LS_BI:1]),
        .rx_ready  (rx_ready),
        .thre_pend (pend),
        .msr_delta (msr_delta),
        .id        (id_d)
    );

    // registered code breaks the read -> clear -> code path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= ID_NONE;
        end else begin
            id_q <= id_d;
        end
    end

    always_comb begin
        lsr_rdata          = '0;
        lsr_rdata[LS_DR]   = rx_ready;
        lsr_rdata[LS_BI:1] = err_flags[3:0];
        lsr_rdata[LS_THRE] = thre;
        lsr_rdata[LS_TEMT] = temt;
        lsr_rdata[LS_FERR] = err_flags[4];
    end

    assign ier_rdata = ier_q;
    assign iir_rdata = {fifo_en, fifo_en, 2'b00, id_q};
    assign irq       = (id_q != ID_NONE);

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       rx_ready,
    input logic       msr_delta,
    input logic       err_overrun,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_break,
    input logic       err_fifo,
    input logic       thr_wr,
    input logic       lsr_rd,
    input logic [7:0] ier_rdata,
    input logic [7:0] iir_rdata,
    input logic [7:0] lsr_rdata
);

    p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ier_rdata[2] && (|lsr_rdata[4:1])) |-> iir_rdata[3:0] == 4'h6);

    p_rx_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ier_rdata[0] && rx_ready && !(ier_rdata[2] && (|lsr_rdata[4:1])))
        |-> iir_rdata[3:0] == 4'h4);

    p_modem_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ier_rdata[3] && msr_delta && !ier_rdata[2] && !ier_rdata[1] && !ier_rdata[0])
        |-> iir_rdata[3:0] == 4'h0);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lsr_rd && !err_overrun && !err_parity && !err_frame && !err_break && !err_fifo)
        |-> (lsr_rdata[4:1] == 4'h0) && !lsr_rdata[7]);

    p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thr_wr) |-> lsr_rdata[6:5] == 2'b00);

    p_prog_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_en && ier_rdata[7]) |-> !lsr_rdata[5]);

endmodule

bind uart_irq_status uart_irq_status_chk u_chk (.*);

// File: tb/uart_irq_status_bench.sv
`timescale 1ns/1ps
module uart_irq_status_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, ier_wr, fifo_en, rx_ready, msr_delta, thr_wr, tx_done, iir_rd, lsr_rd;
    logic       err_overrun, err_parity, err_frame, err_break, err_fifo;
    logic [7:0] ier_wdata, ier_rdata, iir_rdata, lsr_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    uart_irq_status u_uart_irq_status (.*);

    // [15:12] enable bits 3:0, [11] rx_ready, [10] break event,
    // [9] tx_done (arms request), [8] msr_delta, [3:0] expected code
    localparam logic [15:0] VEC [10] = '{
        16'hFF06, 16'hFB04, 16'hF302, 16'hF100, 16'h0F01,
        16'hB401, 16'hAB02, 16'h8F00, 16'h4406, 16'h1C04
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_wr = 1'b1; ier_wdata = v;
        nxt();
        ier_wr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; ier_wr = 0; ier_wdata = 0; fifo_en = 0; rx_ready = 0;
        msr_delta = 0; thr_wr = 0; tx_done = 0; iir_rd = 0; lsr_rd = 0;
        err_overrun = 0; err_parity = 0; err_frame = 0; err_break = 0; err_fifo = 0;
        repeat (3) nxt();
        rst_n = 1'b1;
        #0.5;
        chk("R1 lsr", lsr_rdata, 8'h60);
        chk("R1 ier", ier_rdata, 8'h00);
        chk("R1 iir", iir_rdata, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        fifo_en = 1'b1;
        #0.5;
        chk("R6 upper nibble", iir_rdata, 8'hC1);
        fifo_en = 1'b0;

        nxt();
        thr_wr = 1'b1;
        nxt();
        thr_wr = 1'b0;
        chk("R9 load clears", lsr_rdata, 8'h00);

        // priority table: R2 R3 R4 R5 R6
        for (int i = 0; i < 10; i++) begin
            ier_wr = 1'b1; ier_wdata = {4'h0, VEC[i][15:12]};
            rx_ready = VEC[i][11]; err_break = VEC[i][10];
            tx_done = VEC[i][9]; msr_delta = VEC[i][8];
            nxt();
            ier_wr = 1'b0; err_break = 1'b0; tx_done = 1'b0;
            nxt();
            chk($sformatf("R2/R3/R4/R5 vec %0d code", i), iir_rdata, {4'h0, VEC[i][3:0]});
            chk($sformatf("R6 vec %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][3:0] != 4'h1});
            thr_wr = 1'b1; lsr_rd = 1'b1; rx_ready = 1'b0; msr_delta = 1'b0;
            nxt();
            thr_wr = 1'b0; lsr_rd = 1'b0;
        end

        // R12 lag and R4 / R9 finish
        wr_ier(8'h02);
        tx_done = 1'b1;
        nxt();
        tx_done = 1'b0;
        chk("R12 code not yet moved", iir_rdata, 8'h01);
        chk("R9 finish sets 6:5", lsr_rdata, 8'h60);
        nxt();
        chk("R4 thre code", iir_rdata, 8'h02);
        chk("R6 irq high", {7'd0, irq}, 8'h01);

        // R7 read while empty code shown
        iir_rd = 1'b1;
        nxt();
        iir_rd = 1'b0;
        nxt();
        chk("R7 read clears request", iir_rdata, 8'h01);

        // R11 re-arm by enable write
        wr_ier(8'h02);
        nxt();
        chk("R11 rearm", iir_rdata, 8'h02);

        // R7 read while receive code masks the request
        rx_ready = 1'b1;
        wr_ier(8'h03);
        nxt();
        chk("R7 rx shown", iir_rdata, 8'h04);
        iir_rd = 1'b1;
        nxt();
        iir_rd = 1'b0; rx_ready = 1'b0;
        nxt();
        chk("R7 request kept", iir_rdata, 8'h02);

        // R8 sticky errors and clearing read
        err_overrun = 1; err_parity = 1; err_frame = 1; err_fifo = 1;
        nxt();
        err_overrun = 0; err_parity = 0; err_frame = 0; err_fifo = 0;
        chk("R8 before read", lsr_rdata, 8'hEE);
        lsr_rd = 1'b1;
        nxt();
        lsr_rd = 1'b0;
        chk("R8 after read", lsr_rdata, 8'h60);
        lsr_rd = 1'b1; err_parity = 1'b1;
        nxt();
        lsr_rd = 1'b0; err_parity = 1'b0;
        chk("R8 event beats read", lsr_rdata, 8'h64);
        lsr_rd = 1'b1;
        nxt();
        lsr_rd = 1'b0;

        // R10 programmable empty mode
        fifo_en = 1'b1;
        wr_ier(8'h82);
        nxt();
        chk("R10 bit5 masked", lsr_rdata, 8'h40);
        thr_wr = 1'b1;
        nxt();
        thr_wr = 1'b0;
        chk("R9 load in mode", lsr_rdata, 8'h00);
        nxt();
        chk("R6 fifo nibble none", iir_rdata, 8'hC1);
        tx_done = 1'b1;
        nxt();
        tx_done = 1'b0;
        nxt();
        chk("R10 finish keeps bit5 low", lsr_rdata, 8'h40);
        chk("R10 request raised", iir_rdata, 8'hC2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule